// File: doc/BRIEF.md
# Packed String Compare Engine

This block compares two 128-bit operands lane by lane and returns a per-element result mask. The operands are treated either as sixteen 8-bit elements or as eight 16-bit elements. Element 0 sits in the least significant bits, and result bit j belongs to element j of the second operand. A start strobe launches an operation. From that point the block builds the complete cross-comparison of every first-operand element against every second-operand element, as three relations: equal, greater-or-equal and less-or-equal. It then reduces that matrix in one of four ways selected by a two-bit mode code.

There are four modes. Per-position equality compares element j of one operand with element j of the other. Set membership asks whether an element appears anywhere in the other operand. Substring search along the matrix diagonals finds where the first operand starts inside the second. Range checking treats the first operand as (low, high) bound pairs. Alongside the mask, the block reports the position of the lowest set bit and a flag that says the mask is empty. A one-cycle done pulse marks that the results are valid. New operations may be started on every cycle.

Top module: `strmatch_engine`

## Requirements
- R1: While `rst_n` is low and after its release, before any operation completes, `done_o`, `mask_o`, `index_o` and `nomatch_o` are all 0.
- R2: A start sampled at a rising edge produces a single-cycle `done_o` pulse after the second following rising edge. Starts may be issued back to back. Between pulses, `mask_o`, `index_o` and `nomatch_o` hold their last values.
- R3: Mode code 2'b00 (per-position equality): mask bit j is 1 when element j of `src2_i` equals element j of `src1_i`.
- R4: Mode code 2'b01 (set membership): mask bit j is 1 when element j of `src2_i` equals at least one element of `src1_i`.
- R5: Mode code 2'b10 (ranges): elements 2p and 2p+1 of `src1_i` are the inclusive unsigned low and high bounds of range p. Mask bit j is 1 when element j of `src2_i` is greater than or equal to some low bound and less than or equal to the paired high bound.
- R6: Mode code 2'b11 (substring): mask bit j is 1 when, for every k, either j+k is at or beyond the element count, or element k of `src1_i` equals element j+k of `src2_i`. A prefix of `src1_i` that matches the tail of `src2_i` therefore counts as a hit.
- R7: With `wide_i` = 0 the operands hold 16 byte elements (element i at bits 8i+7:8i). With `wide_i` = 1 they hold 8 word elements (element i at bits 16i+15:16i), all 16 bits take part in every compare, and `mask_o[15:8]` is 0.
- R8: `index_o` is the position of the lowest set mask bit. When the mask is zero it is the element count: 16 in byte mode, 8 in word mode.
- R9: `nomatch_o` is 1 exactly when the completed mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches one compare operation |
| wide_i | input | 1 | Element size: 0 = bytes, 1 = 16-bit words |
| mode_i | input | 2 | Reduction mode code (see R3 to R6) |
| src1_i | input | 128 | First operand: pattern, set or range bounds |
| src2_i | input | 128 | Second operand: the string being scanned |
| mask_o | output | 16 | Result mask, bit j for element j of `src2_i` |
| index_o | output | 5 | Lowest set mask bit, or the element count |
| nomatch_o | output | 1 | High when the mask is zero |
| done_o | output | 1 | One-cycle pulse marking valid results |

## Verification
Each mode is driven with text operands in both element sizes. Hits are placed at scattered positions, so that a row-for-column swap or a shifted diagonal produces a different mask. One substring case has a match only at the tail and another has none, which separates the run-off-the-end rule from a strict full match. In word mode, elements are used that share a low byte but differ in the high byte, which exposes a compare that only looks at 8 bits. Range bounds are probed one below, on and one above each limit, and the mask-empty case checks the element-count index for both sizes.

// File: rtl/strmatch_pkg.sv
package strmatch_pkg;

   typedef enum logic [1:0] {
      MODE_EACH  = 2'b00,
      MODE_ANY   = 2'b01,
      MODE_RANGE = 2'b10,
      MODE_ORDER = 2'b11
   } cmp_mode_e;

endpackage

// File: rtl/strmatch_matrix.sv
module strmatch_matrix #(
   parameter int DATA_W = 128,
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16,
   localparam int NB = DATA_W / BYTE_W,
   localparam int NW = DATA_W / WORD_W
) (
   input  logic                       wide,
   input  logic [DATA_W-1:0]          src1,
   input  logic [DATA_W-1:0]          src2,
   output logic [NB-1:0][NB-1:0]      eq_m,
   output logic [NB-1:0][NB-1:0]      ge_m,
   output logic [NB-1:0][NB-1:0]      le_m
);

   // row i = element i of src1, column j = element j of src2
   for (genvar i = 0; i < NB; i++) begin : g_row
      for (genvar j = 0; j < NB; j++) begin : g_col
         logic [BYTE_W-1:0] a_b, b_b;
         assign a_b = src1[i*BYTE_W +: BYTE_W];
         assign b_b = src2[j*BYTE_W +: BYTE_W];
         if (i < NW && j < NW) begin : g_both
            logic [WORD_W-1:0] a_w, b_w;
            assign a_w = src1[i*WORD_W +: WORD_W];
            assign b_w = src2[j*WORD_W +: WORD_W];
            assign eq_m[i][j] = wide ? (b_w == a_w) : (b_b == a_b);
            assign ge_m[i][j] = wide ? (b_w >= a_w) : (b_b >= a_b);
            assign le_m[i][j] = wide ? (b_w <= a_w) : (b_b <= a_b);
         end else begin : g_byte_only
            assign eq_m[i][j] = !wide && (b_b == a_b);
            assign ge_m[i][j] = !wide && (b_b >= a_b);
            assign le_m[i][j] = !wide && (b_b <= a_b);
         end
      end
   end

endmodule

// File: rtl/strmatch_reduce.sv
module strmatch_reduce
   import strmatch_pkg::*;
#(
   parameter int NB = 16,
   parameter int NW = 8
) (
   input  logic                   wide,
   input  cmp_mode_e              mode,
   input  logic [NB-1:0][NB-1:0]  eq_m,
   input  logic [NB-1:0][NB-1:0]  ge_m,
   input  logic [NB-1:0][NB-1:0]  le_m,
   output logic [NB-1:0]          mask
);

   localparam int NPAIR = NB / 2;

   logic [NB-1:0] each_v, any_v, rng_v, ordb_v, ordw_v, live_v;
   logic [NB-1:0] pick_v;

   for (genvar j = 0; j < NB; j++) begin : g_col
      logic any_b, rng_b, ordb_b, ordw_b;

      always_comb begin
         any_b = 1'b0;
         for (int i = 0; i < NB; i++) any_b = any_b | eq_m[i][j];
      end

      always_comb begin
         rng_b = 1'b0;
         for (int p = 0; p < NPAIR; p++)
            rng_b = rng_b | (ge_m[2*p][j] & le_m[2*p+1][j]);
      end

      // diagonal starting at column j; cells past the end count as hits
      always_comb begin
         ordb_b = 1'b1;
         for (int k = 0; k < NB; k++)
            if (j + k < NB) ordb_b = ordb_b & eq_m[k][(j+k) % NB];
      end

      if (j < NW) begin : g_wlane
         always_comb begin
            ordw_b = 1'b1;
            for (int k = 0; k < NW; k++)
               if (j + k < NW) ordw_b = ordw_b & eq_m[k][(j+k) % NW];
         end
         assign live_v[j] = 1'b1;
      end else begin : g_nolane
         assign ordw_b    = 1'b0;
         assign live_v[j] = !wide;
      end

      assign each_v[j] = eq_m[j][j];
      assign any_v[j]  = any_b;
      assign rng_v[j]  = rng_b;
      assign ordb_v[j] = ordb_b;
      assign ordw_v[j] = ordw_b;
   end

   always_comb begin
      unique case (mode)
         MODE_EACH:  pick_v = each_v;
         MODE_ANY:   pick_v = any_v;
         MODE_RANGE: pick_v = rng_v;
         MODE_ORDER: pick_v = wide ? ordw_v : ordb_v;
         default:    pick_v = '0;
      endcase
   end

   assign mask = pick_v & live_v;

endmodule

// File: rtl/strmatch_index.sv
module strmatch_index #(
   parameter int NB = 16,
   parameter int NW = 8,
   parameter int IDX_W = 5
) (
   input  logic             wide,
   input  logic [NB-1:0]    mask,
   output logic [IDX_W-1:0] index,
   output logic             empty
);

   always_comb begin
      index = wide ? IDX_W'(NW) : IDX_W'(NB);
      for (int k = NB - 1; k >= 0; k--)
         if (mask[k]) index = IDX_W'(k);
   end

   assign empty = (mask == '0);

endmodule

// File: rtl/strmatch_engine.sv
module strmatch_engine
   import strmatch_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16,
   localparam int NB    = DATA_W / BYTE_W,
   localparam int NW    = DATA_W / WORD_W,
   localparam int IDX_W = $clog2(NB + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              wide_i,
   input  logic [1:0]        mode_i,
   input  logic [DATA_W-1:0] src1_i,
   input  logic [DATA_W-1:0] src2_i,
   output logic [NB-1:0]     mask_o,
   output logic [IDX_W-1:0]  index_o,
   output logic              nomatch_o,
   output logic              done_o
);

   if (DATA_W % WORD_W != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of WORD_W");
   end
   if (WORD_W != 2 * BYTE_W) begin : g_bad_word
      $error("WORD_W must be twice BYTE_W");
   end
   if (NW % 2 != 0) begin : g_bad_pairs
      $error("element counts must be even for range pairs");
   end

   // stage 1: comparison matrix
   logic [NB-1:0][NB-1:0] eq_c, ge_c, le_c;
   logic [NB-1:0][NB-1:0] eq_q, ge_q, le_q;
   logic                  wide_q, vld_q;
   cmp_mode_e             mode_q;

   strmatch_matrix #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W),
      .WORD_W (WORD_W)
   ) matrix_i (
      .wide (wide_i),
      .src1 (src1_i),
      .src2 (src2_i),
      .eq_m (eq_c),
      .ge_m (ge_c),
      .le_m (le_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         wide_q <= 1'b0;
         mode_q <= MODE_EACH;
         eq_q   <= '0;
         ge_q   <= '0;
         le_q   <= '0;
      end else begin
         vld_q <= start_i;
         if (start_i) begin
            wide_q <= wide_i;
            mode_q <= cmp_mode_e'(mode_i);
            eq_q   <= eq_c;
            ge_q   <= ge_c;
            le_q   <= le_c;
         end
      end
   end

   // stage 2: reduction and index
   logic [NB-1:0]    mask_c;
   logic [IDX_W-1:0] idx_c;
   logic             empty_c;

   strmatch_reduce #(
      .NB (NB),
      .NW (NW)
   ) reduce_i (
      .wide (wide_q),
      .mode (mode_q),
      .eq_m (eq_q),
      .ge_m (ge_q),
      .le_m (le_q),
      .mask (mask_c)
   );

   strmatch_index #(
      .NB    (NB),
      .NW    (NW),
      .IDX_W (IDX_W)
   ) index_i (
      .wide  (wide_q),
      .mask  (mask_c),
      .index (idx_c),
      .empty (empty_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o    <= 1'b0;
         mask_o    <= '0;
         index_o   <= '0;
         nomatch_o <= 1'b0;
      end else begin
         done_o <= vld_q;
         if (vld_q) begin
            mask_o    <= mask_c;
            index_o   <= idx_c;
            nomatch_o <= empty_c;
         end
      end
   end

endmodule

// File: rtl/strmatch_chk.sv
module strmatch_chk #(
   parameter int NB = 16,
   parameter int NW = 8,
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             wide_i,
   input logic [NB-1:0]    mask_o,
   input logic [IDX_W-1:0] index_o,
   input logic             nomatch_o,
   input logic             done_o
);

   assert_start_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> ##2 done_o);

   assert_done_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(start_i, 2));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(mask_o) && $stable(index_o) && $stable(nomatch_o)));

   assert_word_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(wide_i, 2)) |-> (mask_o[NB-1:NW] == '0));

   assert_lowest_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mask_o != '0) |->
         (mask_o[index_o] && ((mask_o & ((NB'(1) << index_o) - NB'(1))) == '0)));

   assert_empty_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mask_o == '0) |->
         (index_o == ($past(wide_i, 2) ? IDX_W'(NW) : IDX_W'(NB))));

   assert_nomatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (nomatch_o == (mask_o == '0)));

endmodule

bind strmatch_engine strmatch_chk #(
   .NB    (NB),
   .NW    (NW),
   .IDX_W (IDX_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .wide_i    (wide_i),
   .mask_o    (mask_o),
   .index_o   (index_o),
   .nomatch_o (nomatch_o),
   .done_o    (done_o)
);

// File: tb/strmatch_engine_tb_top.sv
module strmatch_engine_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         wide_i = 1'b0;
   logic [1:0]   mode_i = 2'b00;
   logic [127:0] src1_i = '0;
   logic [127:0] src2_i = '0;
   logic [15:0]  mask_o;
   logic [4:0]   index_o;
   logic         nomatch_o;
   logic         done_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   strmatch_engine dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .wide_i    (wide_i),
      .mode_i    (mode_i),
      .src1_i    (src1_i),
      .src2_i    (src2_i),
      .mask_o    (mask_o),
      .index_o   (index_o),
      .nomatch_o (nomatch_o),
      .done_o    (done_o)
   );

   typedef struct packed {
      logic         w;
      logic [1:0]   m;
      logic [127:0] s1;
      logic [127:0] s2;
      logic [15:0]  msk;
      logic [4:0]   idx;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 2'b00, 128'("ABCDEFGHIJKLMNOP"), 128'("AxCxExGxIxKxMxOx"), 16'h5555, 5'd0},  // R3
      '{1'b0, 2'b01, 128'("aeiouaeiouaeioua"), 128'("programmingisfun"), 16'h4924, 5'd2},  // R4
      '{1'b0, 2'b10, 128'("AZ09zazazazazaza"), 128'("hello World 42!X"), 16'hB040, 5'd6},  // R5
      '{1'b0, 2'b11, 128'("abcdefghijklmnop"), 128'("0123456789abcdef"), 16'h0400, 5'd10}, // R6 tail
      '{1'b0, 2'b11, 128'("abcdefghijklmnop"), 128'("zzzzzzzzzzzzzzzz"), 16'h0000, 5'd16}, // R6 none
      '{1'b0, 2'b11, 128'("abcdefghijklmnop"), 128'("abcdefghijklmnop"), 16'h0001, 5'd0},  // R6 full
      '{1'b1, 2'b00, 128'("ABCDEFGH"),         128'("ABCDxxxx"),         16'h000F, 5'd0},  // R7 R3
      '{1'b1, 2'b01, 128'("qqqqqqqz"),         128'("abzdzfgq"),         16'h0094, 5'd2},  // R7 R4
      '{1'b1, 2'b10, 128'("afAFzaza"),         128'("gaFzBxf0"),         16'h0056, 5'd1},  // R7 R5
      '{1'b1, 2'b11, 128'("CDEFGHIJ"),         128'("ABCDEFGH"),         16'h0004, 5'd2}   // R7 R6
   };

   // first character of the text becomes element 0
   function automatic logic [127:0] pack_txt(logic [127:0] s, logic w);
      logic [127:0] r = '0;
      for (int i = 0; i < 16; i++)
         if (!w) r[8*i +: 8] = s[8*(15-i) +: 8];
      for (int i = 0; i < 8; i++)
         if (w) r[16*i +: 16] = {8'h00, s[8*(7-i) +: 8]};
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // launch; results are sampled at the negedge after the second rising edge
   task automatic run_op(input logic w, input logic [1:0] m,
                         input logic [127:0] a, input logic [127:0] b);
      @(negedge clk);
      wide_i = w; mode_i = m; src1_i = a; src2_i = b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic expect_res(input logic [15:0] em, input logic [4:0] ei, input string tag);
      check(done_o === 1'b1, {tag, " R2 done"}, 32'(done_o), 32'd1);
      check(mask_o === em, {tag, " mask"}, 32'(mask_o), 32'(em));
      check(index_o === ei, {tag, " R8 index"}, 32'(index_o), 32'(ei));
      check(nomatch_o === (em == 16'h0), {tag, " R9 nomatch"}, 32'(nomatch_o),
            32'(em == 16'h0));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [127:0] a, b;
      repeat (3) @(negedge clk);
      // R1: reset values
      check(done_o === 1'b0 && mask_o === 16'h0 && index_o === 5'd0 && nomatch_o === 1'b0,
            "R1 in reset", {mask_o, 6'd0, index_o, nomatch_o, done_o}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(done_o === 1'b0 && mask_o === 16'h0 && index_o === 5'd0 && nomatch_o === 1'b0,
            "R1 after release", {mask_o, 6'd0, index_o, nomatch_o, done_o}, 32'd0);

      // table walk: R3 R4 R5 R6 R7
      for (int v = 0; v < NV; v++) begin
         run_op(TBL[v].w, TBL[v].m, pack_txt(TBL[v].s1, TBL[v].w),
                pack_txt(TBL[v].s2, TBL[v].w));
         expect_res(TBL[v].msk, TBL[v].idx, $sformatf("vec%0d R3-6", v));
      end

      // R2: single pulse and hold afterwards
      @(negedge clk);
      check(done_o === 1'b0, "R2 pulse width", 32'(done_o), 32'd0);
      check(mask_o === 16'h0004 && index_o === 5'd2, "R2 hold", 32'(mask_o), 32'h4);

      // R7: word compare uses the high byte (low bytes equal everywhere)
      a = '0; b = '0;
      for (int i = 0; i < 8; i++) begin
         a[16*i +: 16] = 16'h0141;
         b[16*i +: 16] = (i == 3) ? 16'h0141 : 16'h0241;
      end
      run_op(1'b1, 2'b00, a, b);
      expect_res(16'h0008, 5'd3, "R7 high byte");

      // R5: inclusive bounds 0x30..0x39, probes 0x2f 0x30 0x39 0x3a
      a = '0; b = '0;
      for (int p = 0; p < 8; p++) begin
         a[16*p +: 8]     = (p == 0) ? 8'h30 : 8'h7a;
         a[16*p + 8 +: 8] = (p == 0) ? 8'h39 : 8'h61;
      end
      b[7:0] = 8'h2f; b[15:8] = 8'h30; b[23:16] = 8'h39; b[31:24] = 8'h3a;
      for (int j = 4; j < 16; j++) b[8*j +: 8] = 8'hff;
      run_op(1'b0, 2'b10, a, b);
      expect_res(16'h0006, 5'd1, "R5 bounds");

      // R8: empty word mask reports 8
      run_op(1'b1, 2'b00, pack_txt(128'("AAAAAAAA"), 1'b1), pack_txt(128'("BBBBBBBB"), 1'b1));
      expect_res(16'h0000, 5'd8, "R8 word empty");

      // R2: back-to-back starts give consecutive results
      @(negedge clk);
      wide_i = 1'b0; mode_i = 2'b00;
      src1_i = pack_txt(128'("ABCDEFGHIJKLMNOP"), 1'b0);
      src2_i = pack_txt(128'("AxCxExGxIxKxMxOx"), 1'b0);
      start_i = 1'b1;
      @(negedge clk);
      mode_i = 2'b01;
      src1_i = pack_txt(128'("aeiouaeiouaeioua"), 1'b0);
      src2_i = pack_txt(128'("programmingisfun"), 1'b0);
      @(negedge clk);
      start_i = 1'b0;
      expect_res(16'h5555, 5'd0, "R2 first of pair");
      @(negedge clk);
      expect_res(16'h4924, 5'd2, "R2 second of pair");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule